// File: doc/BRIEF.md
# Stream Width Converter

This block joins two valid/ready streams whose data widths differ by a whole-number factor. When the output is wider, it collects several narrow tokens from the input and emits them together as one wide word. When the output is narrower, it takes one wide word and emits its narrow tokens one at a time. A packet-end flag crosses the width change. A packet end on a narrow input closes a wide word early. A packet end on a wide input appears only with the final narrow token of that word.

An elaboration parameter sets the token order. By default the earliest token sits in the least significant lane. With the parameter set, it sits in the most significant lane. A count output tells how many narrow tokens in the current wide output word are real. A word that was closed early therefore shows a count below the ratio. If neither width divides the other, elaboration stops with an error. If the widths are equal, the block is a direct wire-through with a count of one.

Top module: `width_adapter`

## Requirements
- R1: Packing (narrow to wide), with the default order, puts the first token of each word in lane 0 (bits [N-1:0]). With 8-bit tokens packed into 32 bits, 0x11, 0x22, 0x33, 0x44 give 0x44332211.
- R2: A narrow token with in_last set closes the current wide word at once. That word carries out_last = 1, and its unfilled lanes are zero. After 0x11..0x88, a ninth token 0x99 with in_last gives 0x00000099.
- R3: Splitting (wide to narrow), with the default order, emits lane 0 first. The word 0x44332211 gives 0x11, 0x22, 0x33, 0x44.
- R4: When splitting, out_last is 1 only on the final narrow token of a wide word that has in_last set. It is 0 on every earlier token.
- R5: With REVERSE = 1 the first token uses the highest lane instead of lane 0, in both directions. The 8-bit tokens 0x11..0x44 pack to 0x11223344, and the word 0x44332211 splits to 0x44, 0x33, 0x22, 0x11.
- R6: When packing, out_count equals the number of filled lanes in the word: RATIO for a full word, fewer for a word closed early. When splitting, out_count is 1.
- R7: With input valid and output ready held high, a token is transferred on every clock, with no idle cycles.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_last and out_count do not change. No token is lost or duplicated under any stall pattern.
- R9: Synchronous reset discards a partly built or partly sent word. Out of reset, out_valid is low, and the next token starts at the first lane.
- R10: When splitting, in_ready is high only in the cycle in which the final narrow token of the current word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Input token taken this cycle when in_valid is high |
| in_data | input | IN_W | Input token |
| in_last | input | 1 | Input token ends a packet |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream takes the output token |
| out_data | output | OUT_W | Output token |
| out_last | output | 1 | Output token ends a packet |
| out_count | output | CNT_W | Valid narrow tokens in the output word |

## Verification
The assertions assume that upstream follows the valid/ready contract. Once in_valid is raised, it stays high and in_data/in_last stay unchanged until in_ready accepts the token. This matters most when splitting, because the output lanes are taken straight from the held wide word. The stimulus keeps a token pending until it is accepted. It varies only when a new token is first offered, and it varies out_ready freely. It sweeps both directions and both lane orders at a ratio of four, using packet ends at irregular positions.

// File: rtl/wadp_pkg.sv
package wadp_pkg;

    typedef enum logic [1:0] {
        WADP_PASS,
        WADP_PACK,
        WADP_SPLIT
    } wadp_mode_e;

    function automatic wadp_mode_e pick_mode(input int a, input int b);
        if (a == b) return WADP_PASS;
        if (b > a) return WADP_PACK;
        return WADP_SPLIT;
    endfunction

    function automatic int ratio_of(input int a, input int b);
        return (a > b) ? (a / b) : (b / a);
    endfunction

    function automatic bit widths_ok(input int a, input int b);
        return (a >= b) ? ((a % b) == 0) : ((b % a) == 0);
    endfunction

endpackage

// File: rtl/wadp_pack.sv
module wadp_pack #(
    parameter int  NARROW_W = 8,
    parameter int  RATIO    = 4,
    parameter bit  REVERSE  = 1'b0,
    parameter int  CNT_W    = 3,
    localparam int WIDE_W   = NARROW_W * RATIO,
    localparam int IDX_W    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NARROW_W-1:0] in_data,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WIDE_W-1:0]   out_data,
    output logic                out_last,
    output logic [CNT_W-1:0]    out_count
);

    typedef struct packed {
        logic [WIDE_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
        logic              vld;
        logic [WIDE_W-1:0] word;
        logic              last;
        logic [CNT_W-1:0]  cnt;
    } pack_st_t;

    pack_st_t st_d, st_q;

    logic [IDX_W-1:0]  slot_sel;
    logic [WIDE_W-1:0] lane_put;
    logic              take;
    logic              at_end;

    assign slot_sel = REVERSE ? (IDX_W'(RATIO - 1) - st_q.idx) : st_q.idx;
    assign at_end   = (st_q.idx == IDX_W'(RATIO - 1));

    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        assign lane_put[g*NARROW_W +: NARROW_W] =
            (slot_sel == IDX_W'(g)) ? in_data : '0;
    end

    assign in_ready = !st_q.vld || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (take) begin
            if (in_last || at_end) begin
                st_d.word = st_q.acc | lane_put;
                st_d.vld  = 1'b1;
                st_d.last = in_last;
                st_d.cnt  = CNT_W'(st_q.idx) + CNT_W'(1);
                st_d.acc  = '0;
                st_d.idx  = '0;
            end else begin
                st_d.acc = st_q.acc | lane_put;
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.word;
    assign out_last  = st_q.last;
    assign out_count = st_q.cnt;

endmodule

// File: rtl/wadp_split.sv
module wadp_split #(
    parameter int  NARROW_W = 8,
    parameter int  RATIO    = 4,
    parameter bit  REVERSE  = 1'b0,
    localparam int WIDE_W   = NARROW_W * RATIO,
    localparam int IDX_W    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WIDE_W-1:0]   in_data,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [NARROW_W-1:0] out_data,
    output logic                out_last
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } split_st_t;

    split_st_t st_d, st_q;

    logic [NARROW_W-1:0] lane [RATIO];
    logic [IDX_W-1:0]    slot_sel;
    logic                at_end;

    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        assign lane[g] = in_data[g*NARROW_W +: NARROW_W];
    end

    assign slot_sel  = REVERSE ? (IDX_W'(RATIO - 1) - st_q.idx) : st_q.idx;
    assign at_end    = (st_q.idx == IDX_W'(RATIO - 1));

    assign out_valid = in_valid;
    assign out_data  = lane[slot_sel];
    assign out_last  = in_last && at_end;
    assign in_ready  = out_ready && at_end;

    always_comb begin
        st_d = st_q;
        if (in_valid && out_ready) begin
            st_d.idx = at_end ? '0 : (st_q.idx + IDX_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/width_adapter.sv
module width_adapter
    import wadp_pkg::*;
#(
    parameter int  IN_W    = 8,
    parameter int  OUT_W   = 32,
    parameter bit  REVERSE = 1'b0,
    localparam int RATIO   = ratio_of(IN_W, OUT_W),
    localparam int CNT_W   = $clog2(RATIO + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    output logic [CNT_W-1:0] out_count
);

    localparam wadp_mode_e MODE = pick_mode(IN_W, OUT_W);

    if (!widths_ok(IN_W, OUT_W)) begin : g_bad
        $error("width_adapter: IN_W and OUT_W must divide one another");
    end else if (MODE == WADP_PACK) begin : g_pack
        wadp_pack #(
            .NARROW_W (IN_W),
            .RATIO    (RATIO),
            .REVERSE  (REVERSE),
            .CNT_W    (CNT_W)
        ) u_pack (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (in_data),
            .in_last   (in_last),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (out_data),
            .out_last  (out_last),
            .out_count (out_count)
        );
    end else if (MODE == WADP_SPLIT) begin : g_split
        wadp_split #(
            .NARROW_W (OUT_W),
            .RATIO    (RATIO),
            .REVERSE  (REVERSE)
        ) u_split (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (in_data),
            .in_last   (in_last),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (out_data),
            .out_last  (out_last)
        );
        assign out_count = CNT_W'(1);
    end else begin : g_pass
        assign out_valid = in_valid;
        assign in_ready  = out_ready;
        assign out_data  = in_data;
        assign out_last  = in_last;
        assign out_count = CNT_W'(1);
    end

endmodule

// File: rtl/width_adapter_chk.sv
module width_adapter_chk
    import wadp_pkg::*;
#(
    parameter int  IN_W    = 8,
    parameter int  OUT_W   = 32,
    parameter bit  REVERSE = 1'b0,
    localparam int RATIO   = ratio_of(IN_W, OUT_W),
    localparam int CNT_W   = $clog2(RATIO + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_last,
    input logic [CNT_W-1:0] out_count
);

    localparam wadp_mode_e MODE = pick_mode(IN_W, OUT_W);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_last) && $stable(out_count));

    if (MODE == WADP_PACK) begin : g_pack_chk
        // R6
        count_range_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_count >= CNT_W'(1)) && (out_count <= CNT_W'(RATIO)));
        // R2
        short_word_last_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid && (out_count != CNT_W'(RATIO)) |-> out_last);
        // R2
        flush_on_last_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid && in_ready && in_last |=> out_valid && out_last);
        // R7
        no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
            out_ready |-> in_ready);
    end else if (MODE == WADP_SPLIT) begin : g_split_chk
        // R10
        wide_ack_chk: assert property (@(posedge clk) disable iff (rst)
            in_ready |-> out_ready);
        // R4
        last_from_input_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid && out_last |-> in_last);
        // R6
        unit_count_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_count == CNT_W'(1));
    end

endmodule

bind width_adapter width_adapter_chk #(
    .IN_W    (IN_W),
    .OUT_W   (OUT_W),
    .REVERSE (REVERSE)
) u_width_adapter_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_count (out_count)
);

// File: tb/width_adapter_bench.sv
`timescale 1ns/1ps
module width_adapter_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // packing instances: 8 -> 32, index = REVERSE
    logic        up_iv [2];
    logic        up_ir [2];
    logic [7:0]  up_id [2];
    logic        up_il [2];
    logic        up_ov [2];
    logic        up_or [2];
    logic [31:0] up_od [2];
    logic        up_ol [2];
    logic [2:0]  up_oc [2];
    // splitting instances: 32 -> 8
    logic        dn_iv [2];
    logic        dn_ir [2];
    logic [31:0] dn_id [2];
    logic        dn_il [2];
    logic        dn_ov [2];
    logic        dn_or [2];
    logic [7:0]  dn_od [2];
    logic        dn_ol [2];
    logic [2:0]  dn_oc [2];

    for (genvar r = 0; r < 2; r++) begin : g_up
        width_adapter #(.IN_W(8), .OUT_W(32), .REVERSE(r)) u_width_adapter (
            .clk(clk), .rst(rst),
            .in_valid(up_iv[r]), .in_ready(up_ir[r]), .in_data(up_id[r]), .in_last(up_il[r]),
            .out_valid(up_ov[r]), .out_ready(up_or[r]), .out_data(up_od[r]),
            .out_last(up_ol[r]), .out_count(up_oc[r]));
    end
    for (genvar r = 0; r < 2; r++) begin : g_dn
        width_adapter #(.IN_W(32), .OUT_W(8), .REVERSE(r)) u_width_adapter (
            .clk(clk), .rst(rst),
            .in_valid(dn_iv[r]), .in_ready(dn_ir[r]), .in_data(dn_id[r]), .in_last(dn_il[r]),
            .out_valid(dn_ov[r]), .out_ready(dn_or[r]), .out_data(dn_od[r]),
            .out_last(dn_ol[r]), .out_count(dn_oc[r]));
    end

    logic [31:0] src_data [64];
    bit          src_last [64];
    int          src_n;
    logic [31:0] exp_data [256];
    bit          exp_last [256];
    int          exp_cnt  [256];
    int          exp_n;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic build_up(input int rev);
        logic [31:0] acc = '0;
        int j = 0;
        exp_n = 0;
        for (int k = 0; k < src_n; k++) begin
            int slot = rev ? 3 - j : j;
            acc = acc | ({24'b0, src_data[k][7:0]} << (8 * slot));
            j++;
            if (src_last[k] || j == 4) begin
                exp_data[exp_n] = acc;
                exp_last[exp_n] = src_last[k];
                exp_cnt[exp_n]  = j;
                exp_n++;
                acc = '0;
                j = 0;
            end
        end
    endtask

    task automatic build_dn(input int rev);
        exp_n = 0;
        for (int k = 0; k < src_n; k++) begin
            for (int i = 0; i < 4; i++) begin
                int slot = rev ? 3 - i : i;
                exp_data[exp_n] = (src_data[k] >> (8 * slot)) & 32'hff;
                exp_last[exp_n] = src_last[k] && (i == 3);
                exp_cnt[exp_n]  = 1;
                exp_n++;
            end
        end
    endtask

    // mode 0: always valid / always ready; mode 1: irregular valid and ready
    task automatic run(input bit down, input int r, input int mode, input string req);
        int sent = 0, got = 0, cyc = 0;
        int stall_bad = 0, gap = 0, ack_bad = 0;
        bit held = 0, have_prev = 0, prev_l = 0;
        logic [31:0] prev_d = '0;
        logic [2:0]  prev_c = '0;
        while (got < exp_n && cyc < 4000) begin
            bit vld, rdy, ir, ov, ol;
            logic [31:0] od;
            logic [2:0]  oc;
            @(negedge clk);
            vld = (sent < src_n) && (held || mode == 0 || ((cyc * 7 + 3) % 5 != 0));
            rdy = (mode == 0) || ((cyc * 3 + 1) % 4 != 0);
            if (!down) begin
                up_iv[r] = vld; up_id[r] = src_data[sent < src_n ? sent : 0][7:0];
                up_il[r] = vld && src_last[sent < src_n ? sent : 0]; up_or[r] = rdy;
            end else begin
                dn_iv[r] = vld; dn_id[r] = src_data[sent < src_n ? sent : 0];
                dn_il[r] = vld && src_last[sent < src_n ? sent : 0]; dn_or[r] = rdy;
            end
            #1;
            if (!down) begin
                ir = up_ir[r]; ov = up_ov[r]; od = up_od[r]; ol = up_ol[r]; oc = up_oc[r];
            end else begin
                ir = dn_ir[r]; ov = dn_ov[r]; od = {24'b0, dn_od[r]}; ol = dn_ol[r]; oc = dn_oc[r];
            end
            if (have_prev && !(ov && od == prev_d && ol == prev_l && oc == prev_c)) stall_bad++;
            have_prev = ov && !rdy;
            prev_d = od; prev_l = ol; prev_c = oc;
            if (mode == 0) begin
                if (!down && sent < src_n && !ir) gap++;
                if (down && !ov) gap++;
            end
            if (down && vld && ir && !(ov && rdy && (got % 4) == 3)) ack_bad++;
            if (ov && rdy) begin
                chk(od == exp_data[got], req, od, exp_data[got]);
                chk(ol == exp_last[got], down ? "R4" : "R2", {31'b0, ol}, {31'b0, exp_last[got]});
                chk(oc == 3'(exp_cnt[got]), "R6", {29'b0, oc}, exp_cnt[got]);
                got++;
            end
            if (vld && ir) sent++;
            held = vld && !ir;
            cyc++;
        end
        @(negedge clk);
        if (!down) begin up_iv[r] = 0; up_il[r] = 0; up_or[r] = 0; end
        else begin dn_iv[r] = 0; dn_il[r] = 0; dn_or[r] = 0; end
        chk(got == exp_n, "R8", got, exp_n);
        chk(stall_bad == 0, "R8", stall_bad, 0);
        if (mode == 0) chk(gap == 0, "R7", gap, 0);
        if (down) chk(ack_bad == 0, "R10", ack_bad, 0);
    endtask

    task automatic load_nine();
        src_n = 9;
        for (int k = 0; k < 9; k++) begin
            src_data[k] = 32'h11 * (k + 1);
            src_last[k] = (k == 8);
        end
    endtask

    task automatic load_up_sweep();
        src_n = 23;
        for (int k = 0; k < 23; k++) begin
            src_data[k] = (k * 37 + 5) & 32'hff;
            src_last[k] = (k % 7 == 6) || (k == 22);
        end
    endtask

    task automatic load_dn_sweep();
        src_n = 8;
        for (int k = 0; k < 8; k++) begin
            src_data[k] = (32'h01010101 * k) ^ 32'h5a3c1e0f;
            src_last[k] = (k % 3 == 2) || (k == 7);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            up_iv[r] = 0; up_id[r] = '0; up_il[r] = 0; up_or[r] = 0;
            dn_iv[r] = 0; dn_id[r] = '0; dn_il[r] = 0; dn_or[r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R9 reset state
        for (int r = 0; r < 2; r++) begin
            chk(up_ov[r] == 0, "R9", up_ov[r], 0);
            chk(up_ir[r] == 1, "R9", up_ir[r], 1);
            chk(dn_ov[r] == 0, "R9", dn_ov[r], 0);
        end

        // R1 / R2: nine bytes, default order
        load_nine(); build_up(0);
        chk(exp_data[0] == 32'h44332211 && exp_data[2] == 32'h99, "R1", exp_data[0], 32'h44332211);
        run(0, 0, 0, "R1");
        // R5: reversed packing
        load_nine(); build_up(1);
        run(0, 1, 0, "R5");

        // R3 / R4: two words, default and reversed
        src_n = 2;
        src_data[0] = 32'h44332211; src_last[0] = 0;
        src_data[1] = 32'h88776655; src_last[1] = 1;
        build_dn(0); run(1, 0, 0, "R3");
        build_dn(1); run(1, 1, 0, "R5");

        // R8 sweeps with stalls, both directions and orders
        for (int r = 0; r < 2; r++) begin
            load_up_sweep(); build_up(r); run(0, r, 1, "R8");
            load_dn_sweep(); build_dn(r); run(1, r, 1, "R8");
        end

        // R9: reset mid-word in packing
        @(negedge clk); up_iv[0] = 1; up_id[0] = 8'haa; up_or[0] = 1;
        @(negedge clk); up_id[0] = 8'hbb;
        @(negedge clk); up_iv[0] = 0; rst = 1;
        @(negedge clk); rst = 0; #1;
        chk(up_ov[0] == 0, "R9", up_ov[0], 0);
        src_n = 4;
        for (int k = 0; k < 4; k++) begin src_data[k] = 32'h11 * (k + 1); src_last[k] = 0; end
        build_up(0); run(0, 0, 0, "R9");

        // R9: reset mid-word in splitting
        @(negedge clk); dn_iv[0] = 1; dn_id[0] = 32'hddccbbaa; dn_or[0] = 1;
        @(negedge clk);
        @(negedge clk); dn_iv[0] = 0; dn_or[0] = 0; rst = 1;
        @(negedge clk); rst = 0;
        src_n = 1; src_data[0] = 32'h44332211; src_last[0] = 1;
        build_dn(0); run(1, 0, 0, "R9");

        finish_run();
    end

endmodule